// File: doc/BRIEF.md
# JTAG-to-SPI Bridge Frame Sequencer

This block runs one SPI flash transaction over a JTAG chain. The flash sits behind a one-bit bridge data register inside an FPGA. The sequencer takes a request made of:

- an 8-bit command,
- an optional 24-bit address,
- a data length in bits,
- a read/write flag,
- write data,
- the number of enabled TAPs on the chain.

It generates TCK, TMS and TDI itself from the system clock and samples TDO. Each request becomes an instruction-register load followed by one data-register scan. The TAP is assumed to rest in Run-Test/Idle before each request.

Inside the data-register scan, the bridge sees the following, in order:

- a single 1 start marker;
- a 32-bit length word, most significant bit first, holding the number of SPI bits minus one;
- the command, then the address if one is present;
- the payload.

Write data follows the header directly. A read first shifts zeros for as many TCK cycles as there are enabled TAPs, which is the round-trip delay through the bypass chain. It then captures the requested number of TDO bits into a byte-packed result, offered with a valid/ready handshake.

The FSM has six states:

- `ST_IDLE`: leaves on an accepted start to `ST_IR_HEAD`.
- `ST_IR_HEAD`: four TMS bits 1,1,0,0 to Shift-IR, then to `ST_IR_SHIFT`.
- `ST_IR_SHIFT`: the instruction bits, then to `ST_IR_TAIL`.
- `ST_IR_TAIL`: TMS 1,1,0,0 through Update-IR and Capture-DR into Shift-DR, then to `ST_DR_SHIFT`.
- `ST_DR_SHIFT`: the framed bits, then to `ST_DR_TAIL`.
- `ST_DR_TAIL`: TMS 1,0 through Update-DR to Run-Test/Idle, then back to `ST_IDLE` with a done pulse.

Every state moves on only at the end of its last TCK period.

Top module: `jtag_spi_frame_seq`

## Requirements
- R1: Every accepted request starts with an instruction load, even when the same instruction is already loaded. The JTAG bits are, in order:
  - TMS 1,1,0,0;
  - IR_LEN bits of IR_CODE, least significant bit first, with TMS high only on the last of them;
  - TMS 1,1,0,0 to reach Shift-DR.

  TDI is 0 on every bit outside the instruction bits.
- R2: Each JTAG bit takes two clock cycles: one with TCK low, then one with TCK high. TMS and TDI change only in the cycle where TCK falls. TDO is sampled at the clock edge that raises TCK. While idle, TCK, TMS and TDI are all 0.
- R3: The first data-register bit is a single 1 marker.
- R4: After the marker come 32 bits, most significant bit first, equal to 7 + data_bits, plus 24 when has_addr is 1.
- R5: The 8-bit command follows the length word, most significant bit first.
- R6: When has_addr is 1, the 24-bit address follows the command, most significant bit first. When has_addr is 0, no address bits are sent.
- R7: On a write, payload bit k follows the header with no gap. Bit k is taken from wr_data[8*(k/8) + 7 - k%8]. TMS is high only on the last data-register bit.
- R8: On a read, TDI is held at 0 for taps + data_bits bits after the header. TDO is ignored during the first taps of these bits. Captured bit k lands in rd_data[8*(k/8) + 7 - k%8], and all bits of rd_data beyond data_bits read 0.
- R9: After the last data-register bit, TMS goes 1 then 0. In the next cycle done is high for exactly one cycle and busy is low.
- R10: A start, and any change of the request inputs, while busy has no effect on the JTAG outputs.
- R11: On a read only, rd_valid rises together with done. It then stays high with rd_data unchanged until a cycle with rd_ready high.
- R12: During and right after reset, tck, tms, tdi, busy, done and rd_valid are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; TCK runs at half its rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe, accepted only while idle |
| is_read | input | 1 | 1 for a read transaction, 0 for a write |
| has_addr | input | 1 | 1 when the 24-bit address is sent |
| cmd | input | 8 | SPI command byte |
| addr | input | 24 | SPI address |
| data_bits | input | DLEN_W | Number of payload bits, up to MAX_DATA_BITS |
| wr_data | input | MAX_DATA_BITS | Write payload, byte-packed, MSB first within each byte |
| taps | input | TAP_CNT_W | Count of enabled TAPs on the chain, at least 1 |
| tck | output | 1 | JTAG test clock |
| tms | output | 1 | JTAG mode select |
| tdi | output | 1 | JTAG data toward the chain |
| tdo | input | 1 | JTAG data from the chain |
| busy | output | 1 | High from acceptance until the TAP is back in Run-Test/Idle |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | MAX_DATA_BITS | Captured read payload |
| rd_valid | output | 1 | Read payload available |
| rd_ready | input | 1 | Consumer takes the read payload |

## Verification
A wrong state or an off-by-one position counter shows up at the ports at once. The TMS or TDI value of the very next TCK period differs from the expected bit stream, at the latest two clock cycles after the slip. Every later bit of the scan is then displaced as well.

A wrong capture offset or wrong bit packing does not show on the JTAG pins. It becomes visible only when done rises, as a wrong rd_data word. For this reason the chain model drives noise on TDO during the alignment zeros.

A bad segment length breaks the TMS exit pattern, which also moves the done pulse away from the cycle the bit count predicts.

// File: rtl/jsq_pkg.sv
package jsq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_IR_HEAD,
        ST_IR_SHIFT,
        ST_IR_TAIL,
        ST_DR_SHIFT,
        ST_DR_TAIL
    } jsq_state_e;

    // data-register header layout, bit positions counted from the marker
    localparam int unsigned LEN_FIRST   = 1;
    localparam int unsigned CMD_FIRST   = 33;
    localparam int unsigned ADDR_FIRST  = 41;
    localparam int unsigned HDR_NOADDR  = 41;
    localparam int unsigned HDR_WITHADR = 65;
    localparam int unsigned NAV_BITS    = 4;   // TMS bits in each head/tail walk

endpackage

// File: rtl/jsq_tck_gen.sv
module jsq_tck_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tck,
    output logic rise,
    output logic fall
);

    logic tck_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tck_q <= 1'b0;
        end else if (run) begin
            tck_q <= ~tck_q;
        end else begin
            tck_q <= 1'b0;
        end
    end

    assign tck  = tck_q;
    assign rise = run & ~tck_q;   // this edge raises TCK
    assign fall = run &  tck_q;   // this edge lowers TCK

endmodule

// File: rtl/jsq_dr_frame.sv
module jsq_dr_frame #(
    parameter int MAXD   = 64,
    parameter int DLEN_W = 7,
    parameter int TAP_W  = 4,
    parameter int POS_W  = 8,
    localparam int KW    = $clog2(MAXD)
) (
    input  logic [POS_W-1:0]  pos,
    input  logic              has_addr,
    input  logic              is_read,
    input  logic [7:0]        cmd,
    input  logic [23:0]       addr,
    input  logic [DLEN_W-1:0] n_bits,
    input  logic [TAP_W-1:0]  taps,
    input  logic [MAXD-1:0]   wr_data,
    output logic              bit_o,
    output logic              last_o,
    output logic              cap_o,
    output logic [KW-1:0]     cap_idx
);

    import jsq_pkg::*;

    logic [31:0]      len_val;
    logic [POS_W-1:0] hdr_end;
    logic [POS_W-1:0] data_start;
    logic [POS_W-1:0] total;
    logic [KW-1:0]    wk;

    always_comb begin
        len_val    = 32'd7 + 32'(n_bits) + (has_addr ? 32'd24 : 32'd0);
        hdr_end    = has_addr ? POS_W'(HDR_WITHADR) : POS_W'(HDR_NOADDR);
        data_start = hdr_end + (is_read ? POS_W'(taps) : POS_W'(0));
        total      = data_start + POS_W'(n_bits);
        wk         = KW'(pos - hdr_end) ^ KW'(7);
        cap_idx    = KW'(pos - data_start) ^ KW'(7);

        bit_o = 1'b0;
        if (pos == '0) begin
            bit_o = 1'b1;
        end else if (pos < POS_W'(CMD_FIRST)) begin
            bit_o = len_val[5'(32 - pos)];
        end else if (pos < POS_W'(ADDR_FIRST)) begin
            bit_o = cmd[3'(40 - pos)];
        end else if (pos < hdr_end) begin
            bit_o = addr[5'(64 - pos)];
        end else if (!is_read) begin
            bit_o = wr_data[wk];
        end

        last_o = (pos == total - 1'b1);
        cap_o  = is_read && (pos >= data_start) && (pos < total);
    end

endmodule

// File: rtl/jsq_rd_pack.sv
module jsq_rd_pack #(
    parameter int MAXD = 64,
    localparam int KW  = $clog2(MAXD)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            cap_en,
    input  logic [KW-1:0]   cap_idx,
    input  logic            tdo,
    output logic [MAXD-1:0] rd_data
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (clear) begin
            rd_data <= '0;
        end else if (cap_en) begin
            rd_data[cap_idx] <= tdo;
        end
    end

endmodule

// File: rtl/jtag_spi_frame_seq.sv
module jtag_spi_frame_seq #(
    parameter int IR_LEN                 = 6,
    parameter logic [IR_LEN-1:0] IR_CODE = 'h02,
    parameter int MAX_DATA_BITS          = 64,
    parameter int TAP_CNT_W              = 4,
    localparam int DLEN_W                = $clog2(MAX_DATA_BITS + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic                     is_read,
    input  logic                     has_addr,
    input  logic [7:0]               cmd,
    input  logic [23:0]              addr,
    input  logic [DLEN_W-1:0]        data_bits,
    input  logic [MAX_DATA_BITS-1:0] wr_data,
    input  logic [TAP_CNT_W-1:0]     taps,
    output logic                     tck,
    output logic                     tms,
    output logic                     tdi,
    input  logic                     tdo,
    output logic                     busy,
    output logic                     done,
    output logic [MAX_DATA_BITS-1:0] rd_data,
    output logic                     rd_valid,
    input  logic                     rd_ready
);

    import jsq_pkg::*;

    localparam int POS_W = $clog2(HDR_WITHADR + (1 << TAP_CNT_W) + MAX_DATA_BITS);
    localparam int IR_IW = (IR_LEN > 1) ? $clog2(IR_LEN) : 1;
    localparam int KW    = $clog2(MAX_DATA_BITS);

    jsq_state_e state, state_nxt;
    logic [POS_W-1:0]         pos;
    logic                     seg_end;
    logic                     run, tck_rise, tck_fall;
    logic                     accept;

    logic                     is_read_q, has_addr_q;
    logic [7:0]               cmd_q;
    logic [23:0]              addr_q;
    logic [DLEN_W-1:0]        n_q;
    logic [TAP_CNT_W-1:0]     taps_q;
    logic [MAX_DATA_BITS-1:0] wr_q;

    logic                     fr_bit, fr_last, fr_cap;
    logic [KW-1:0]            fr_idx;

    assign run    = (state != ST_IDLE);
    assign busy   = run;
    assign accept = start && (state == ST_IDLE);

    jsq_tck_gen u_tck (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (run),
        .tck  (tck),
        .rise (tck_rise),
        .fall (tck_fall)
    );

    jsq_dr_frame #(
        .MAXD  (MAX_DATA_BITS),
        .DLEN_W(DLEN_W),
        .TAP_W (TAP_CNT_W),
        .POS_W (POS_W)
    ) u_frame (
        .pos     (pos),
        .has_addr(has_addr_q),
        .is_read (is_read_q),
        .cmd     (cmd_q),
        .addr    (addr_q),
        .n_bits  (n_q),
        .taps    (taps_q),
        .wr_data (wr_q),
        .bit_o   (fr_bit),
        .last_o  (fr_last),
        .cap_o   (fr_cap),
        .cap_idx (fr_idx)
    );

    jsq_rd_pack #(
        .MAXD(MAX_DATA_BITS)
    ) u_pack (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (accept),
        .cap_en (tck_rise && (state == ST_DR_SHIFT) && fr_cap),
        .cap_idx(fr_idx),
        .tdo    (tdo),
        .rd_data(rd_data)
    );

    // segment length and successor of each state
    always_comb begin
        state_nxt = state;
        seg_end   = 1'b0;
        unique case (state)
            ST_IDLE:     begin state_nxt = ST_IDLE;     seg_end = 1'b0; end
            ST_IR_HEAD:  begin state_nxt = ST_IR_SHIFT; seg_end = (pos == POS_W'(NAV_BITS - 1)); end
            ST_IR_SHIFT: begin state_nxt = ST_IR_TAIL;  seg_end = (pos == POS_W'(IR_LEN - 1)); end
            ST_IR_TAIL:  begin state_nxt = ST_DR_SHIFT; seg_end = (pos == POS_W'(NAV_BITS - 1)); end
            ST_DR_SHIFT: begin state_nxt = ST_DR_TAIL;  seg_end = fr_last; end
            ST_DR_TAIL:  begin state_nxt = ST_IDLE;     seg_end = (pos == POS_W'(1)); end
        endcase
    end

    // state register, position counter, request latch, completion flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            pos        <= '0;
            done       <= 1'b0;
            rd_valid   <= 1'b0;
            is_read_q  <= 1'b0;
            has_addr_q <= 1'b0;
            cmd_q      <= '0;
            addr_q     <= '0;
            n_q        <= '0;
            taps_q     <= '0;
            wr_q       <= '0;
        end else begin
            done <= 1'b0;
            if (rd_valid && rd_ready) begin
                rd_valid <= 1'b0;
            end
            if (accept) begin
                is_read_q  <= is_read;
                has_addr_q <= has_addr;
                cmd_q      <= cmd;
                addr_q     <= addr;
                n_q        <= data_bits;
                taps_q     <= taps;
                wr_q       <= wr_data;
                rd_valid   <= 1'b0;
                state      <= ST_IR_HEAD;
                pos        <= '0;
            end else if (tck_fall) begin
                if (seg_end) begin
                    state <= state_nxt;
                    pos   <= '0;
                    if (state == ST_DR_TAIL) begin
                        done     <= 1'b1;
                        rd_valid <= is_read_q;
                    end
                end else begin
                    pos <= pos + 1'b1;
                end
            end
        end
    end

    // JTAG pin values for the current bit
    always_comb begin
        tms = 1'b0;
        tdi = 1'b0;
        unique case (state)
            ST_IDLE:     begin tms = 1'b0; tdi = 1'b0; end
            ST_IR_HEAD:  begin tms = (pos < POS_W'(2)); end
            ST_IR_SHIFT: begin tms = seg_end; tdi = IR_CODE[IR_IW'(pos)]; end
            ST_IR_TAIL:  begin tms = (pos < POS_W'(2)); end
            ST_DR_SHIFT: begin tms = seg_end; tdi = fr_bit; end
            ST_DR_TAIL:  begin tms = (pos == '0); end
        endcase
    end

endmodule

// File: rtl/jsq_checker.sv
module jsq_checker #(
    parameter int MAXD = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic            busy,
    input logic            done,
    input logic            tck,
    input logic            tms,
    input logic            tdi,
    input logic            rd_valid,
    input logic            rd_ready,
    input logic [MAXD-1:0] rd_data
);

    a_r2_pins_hold_while_high: assert property (@(posedge clk) disable iff (!rst_n)
        tck |-> ($stable(tms) && $stable(tdi)));

    a_r2_high_follows_low: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tck) |=> tck);

    a_r2_low_follows_high: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && tck) |=> !tck);

    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!tck && !tms && !tdi));

    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r9_done_when_free: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    a_r9_end_marks_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    a_r11_result_held: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready && !(start && !busy)) |=> (rd_valid && $stable(rd_data)));

endmodule

bind jtag_spi_frame_seq jsq_checker #(.MAXD(MAX_DATA_BITS)) i_jsq_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .tck     (tck),
    .tms     (tms),
    .tdi     (tdi),
    .rd_valid(rd_valid),
    .rd_ready(rd_ready),
    .rd_data (rd_data)
);

// File: tb/test_jtag_spi_frame_seq.sv
module test_jtag_spi_frame_seq;

    localparam int CLK_PERIOD = 10;
    localparam int IR_LEN = 6;
    localparam logic [IR_LEN-1:0] IR_CODE = 6'h02;
    localparam int MAXD = 64;
    localparam int TW = 4;
    localparam int DW = $clog2(MAXD + 1);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic            is_read = 1'b0;
    logic            has_addr = 1'b0;
    logic [7:0]      cmd = '0;
    logic [23:0]     addr = '0;
    logic [DW-1:0]   data_bits = '0;
    logic [MAXD-1:0] wr_data = '0;
    logic [TW-1:0]   taps = '0;
    logic            tck, tms, tdi;
    logic            tdo = 1'b0;
    logic            busy, done, rd_valid;
    logic            rd_ready = 1'b0;
    logic [MAXD-1:0] rd_data;

    int compared = 0;
    int mismatched = 0;
    bit finished = 0;

    bit    q_tms[$];
    bit    q_tdi[$];
    bit    q_tdo[$];
    string q_tag[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    jtag_spi_frame_seq #(
        .IR_LEN(IR_LEN), .IR_CODE(IR_CODE), .MAX_DATA_BITS(MAXD), .TAP_CNT_W(TW)
    ) i_jtag_spi_frame_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .is_read(is_read), .has_addr(has_addr),
        .cmd(cmd), .addr(addr), .data_bits(data_bits), .wr_data(wr_data), .taps(taps),
        .tck(tck), .tms(tms), .tdi(tdi), .tdo(tdo), .busy(busy), .done(done),
        .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready)
    );

    task automatic chk(string req, string what, int act, int expv);
        compared++;
        if (act != expv) begin
            mismatched++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    task automatic push(bit m, bit d, string tg);
        q_tms.push_back(m);
        q_tdi.push_back(d);
        q_tag.push_back(tg);
    endtask

    task automatic run_txn(bit rd, bit ha, logic [7:0] c, logic [23:0] a, int n, int t,
                           logic [MAXD-1:0] wr);
        logic [MAXD-1:0] exp_rd;
        logic [31:0] len;
        int cap0;
        int nb;
        exp_rd = '0;
        q_tms.delete(); q_tdi.delete(); q_tdo.delete(); q_tag.delete();
        // R1: instruction load path
        push(1, 0, "R1"); push(1, 0, "R1"); push(0, 0, "R1"); push(0, 0, "R1");
        for (int i = 0; i < IR_LEN; i++) push(i == IR_LEN - 1, IR_CODE[i], "R1");
        push(1, 0, "R1"); push(1, 0, "R1"); push(0, 0, "R1"); push(0, 0, "R1");
        // framed data-register scan
        push(0, 1, "R3");
        len = 32'(7 + n + (ha ? 24 : 0));
        for (int j = 31; j >= 0; j--) push(0, len[j], "R4");
        for (int j = 7; j >= 0; j--) push(0, c[j], "R5");
        if (ha) for (int j = 23; j >= 0; j--) push(0, a[j], "R6");
        if (rd) begin
            for (int j = 0; j < t + n; j++) push(0, 0, "R8");
        end else begin
            for (int k = 0; k < n; k++) push(0, wr[8 * (k / 8) + 7 - k % 8], "R7");
        end
        q_tms[q_tms.size() - 1] = 1;
        push(1, 0, "R9"); push(0, 0, "R9");
        cap0 = 4 + IR_LEN + 4 + 1 + 32 + 8 + (ha ? 24 : 0) + t;
        nb = q_tms.size();
        for (int b = 0; b < nb; b++) q_tdo.push_back(1'($urandom));
        for (int k = 0; k < n; k++) exp_rd[8 * (k / 8) + 7 - k % 8] = q_tdo[cap0 + k];

        @(negedge clk);
        start = 1; is_read = rd; has_addr = ha; cmd = c; addr = a;
        data_bits = DW'(n); taps = TW'(t); wr_data = wr;
        for (int b = 0; b < nb; b++) begin
            @(negedge clk);
            start = (b % 5 == 2);   // R10: strobes and altered request while busy
            if (b > 0) begin
                is_read = ~rd; has_addr = ~ha; cmd = ~c; addr = ~a; wr_data = ~wr;
                data_bits = DW'(b % MAXD); taps = TW'(b);
            end
            chk(q_tag[b], "tck low", int'(tck), 0);
            chk(q_tag[b], "tms", int'(tms), int'(q_tms[b]));
            chk(q_tag[b], "tdi", int'(tdi), int'(q_tdi[b]));
            chk("R10", "busy", int'(busy), 1);
            tdo = q_tdo[b];
            @(negedge clk);
            start = 0;
            chk("R2", "tck high", int'(tck), 1);
            chk("R2", "tms held", int'(tms), int'(q_tms[b]));
            chk("R2", "tdi held", int'(tdi), int'(q_tdi[b]));
        end
        @(negedge clk);
        tdo = 0;
        chk("R9", "done", int'(done), 1);
        chk("R9", "busy", int'(busy), 0);
        chk("R2", "idle tck", int'(tck), 0);
        chk("R2", "idle tms", int'(tms), 0);
        chk("R2", "idle tdi", int'(tdi), 0);
        chk("R11", "rd_valid", int'(rd_valid), int'(rd));
        if (rd) begin
            chk("R8", "rd_data lo", int'(rd_data[31:0]), int'(exp_rd[31:0]));
            chk("R8", "rd_data hi", int'(rd_data[63:32]), int'(exp_rd[63:32]));
        end
        @(negedge clk);
        chk("R9", "done dropped", int'(done), 0);
        if (rd) begin
            chk("R11", "rd_valid held", int'(rd_valid), 1);
            chk("R11", "rd_data held lo", int'(rd_data[31:0]), int'(exp_rd[31:0]));
            chk("R11", "rd_data held hi", int'(rd_data[63:32]), int'(exp_rd[63:32]));
            rd_ready = 1;
            @(negedge clk);
            rd_ready = 0;
            chk("R11", "rd_valid cleared", int'(rd_valid), 0);
        end
    endtask

    task automatic check_quiet(string req);
        chk(req, "tck", int'(tck), 0);
        chk(req, "tms", int'(tms), 0);
        chk(req, "tdi", int'(tdi), 0);
        chk(req, "busy", int'(busy), 0);
        chk(req, "done", int'(done), 0);
        chk(req, "rd_valid", int'(rd_valid), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_quiet("R12");
        rst_n = 1;
        @(negedge clk);
        check_quiet("R12");
        run_txn(0, 1, 8'h02, 24'h123456, 16, 1, 64'h0000_0000_0000_A55A);
        run_txn(1, 1, 8'h03, 24'hABCDEF, 24, 3, '0);
        run_txn(1, 0, 8'h9F, 24'h0, 64, 15, '0);
        run_txn(0, 0, 8'h06, 24'h0, 0, 2, '0);
        run_txn(1, 0, 8'h05, 24'h0, 0, 1, '0);
        run_txn(0, 1, 8'hD8, 24'h00F00F, 40, 5, 64'h0123_4567_89AB_CDEF);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: run did not complete");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule